// File: doc/BRIEF.md
# Host I/O Interrupt Unit with Frame-Sync Routing

This block is the interrupt unit of a memory-mapped host I/O peripheral. It sits behind a 32-byte register window that is reached one byte at a time. It latches the completion and error events reported by the host I/O engine into sticky pending bits. An enable mask gates those bits onto a maskable, level-sensitive interrupt line. Software clears a pending bit by writing a one to that bit of the acknowledge register. Software can therefore poll the pending bits, or leave the enables set and run from the interrupt.

The display's frame-sync pulse also passes through this block. A two-bit strap input selects where it goes. It can be dropped, which is the default strap value 0. It can be latched as a third pending bit and so feed the maskable line. Or it can become a one-clock pulse on the non-maskable line, which the enable mask does not affect.

Top module: `hio_irq_unit`

## Requirements
- R1: After reset, the pending bits and the enable mask are zero, and `irq_o`, `nmi_o` and `reg_rdata` are low.
- R2: A `done_evt` pulse sets pending bit 0, and an `err_evt` pulse sets pending bit 1. Each bit reads back at offset 0x11 and stays set until it is acknowledged.
- R3: A write to offset 0x13 clears every pending bit whose data bit is 1. Pending bits whose data bit is 0 do not change.
- R4: If an event arrives in the same cycle as an acknowledge write that clears its bit, the bit stays set.
- R5: `irq_o` is high exactly while some pending bit has its enable bit set. It follows the registers without an added delay and stays high until every enabled pending bit is cleared.
- R6: Offset 0x12 holds the enable mask. Bit i enables pending bit i for i = 0..2. Bits 7..3 read as 0. A write with `reg_sel` low has no effect.
- R7: With `sync_route` at 2'b00 (off) or at the reserved value 2'b11, a `frame_sync` pulse changes neither the pending bits nor `nmi_o`.
- R8: With `sync_route` = 2'b01, a `frame_sync` pulse sets pending bit 2, which is then handled like the other pending bits.
- R9: With `sync_route` = 2'b10, each `frame_sync` pulse gives `nmi_o` high for exactly the next clock, whatever the enable mask holds. Pending bit 2 is not set.
- R10: Reads of offset 0x13 and of every offset other than 0x11 and 0x12 return 0x00. Writes to 0x11 and to unused offsets change nothing.
- R11: Read data appears on `reg_rdata` in the cycle after the read access. In any cycle not preceded by a read, it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe, one byte per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset in the 32-byte window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| done_evt | input | 1 | Request-complete event pulse |
| err_evt | input | 1 | Error event pulse |
| frame_sync | input | 1 | Display frame-sync pulse |
| sync_route | input | 2 | Frame-sync route strap: 00 off, 01 maskable, 10 non-maskable, 11 off |
| irq_o | output | 1 | Maskable interrupt, level |
| nmi_o | output | 1 | Non-maskable interrupt, one-clock pulse |

## Verification
Each result is due one clock edge after its stimulus. The pending and enable registers update at that edge, and `irq_o` follows them with no register in between. `nmi_o` and `reg_rdata` are registered once, so they also change at that same edge. The bench drives each vector just after a falling edge and samples all three outputs shortly after the next rising edge, so every check looks at exactly the cycle in which the response is due. A same-cycle event and acknowledge is driven as one vector, so the priority rule is tested in that single edge.

// File: rtl/hio_irq_pkg.sv
package hio_irq_pkg;

  localparam int NUM_SRC = 3;
  localparam int SRC_DONE = 0;
  localparam int SRC_ERR  = 1;
  localparam int SRC_SYNC = 2;

  localparam logic [4:0] OFS_STATUS = 5'h11;
  localparam logic [4:0] OFS_ENABLE = 5'h12;
  localparam logic [4:0] OFS_ACK    = 5'h13;

  typedef enum logic [1:0] {
    ROUTE_OFF  = 2'b00,
    ROUTE_IRQ  = 2'b01,
    ROUTE_NMI  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  typedef enum logic [1:0] {
    RD_NONE   = 2'b00,
    RD_STATUS = 2'b01,
    RD_ENABLE = 2'b10
  } rd_src_e;

  // Sticky bit update: a set always beats a clear.
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq_level(logic [NUM_SRC-1:0] pend,
                                     logic [NUM_SRC-1:0] en);
    return |(pend & en);
  endfunction

endpackage

// File: rtl/hio_bus_decode.sv
module hio_bus_decode
  import hio_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_wr,
  output logic [NUM_SRC-1:0] en_wdata,
  output logic [NUM_SRC-1:0] ack_mask,
  output logic              rd_stb,
  output rd_src_e           rd_src
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);

  logic wr_stb;
  assign wr_stb   = sel & we;
  assign rd_stb   = sel & ~we;
  assign en_wr    = wr_stb && (addr == A_ENABLE);
  assign en_wdata = wdata[NUM_SRC-1:0];
  assign ack_mask = (wr_stb && (addr == A_ACK)) ? wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    rd_src = RD_NONE;
    if (addr == A_STATUS)      rd_src = RD_STATUS;
    else if (addr == A_ENABLE) rd_src = RD_ENABLE;
  end

endmodule

// File: rtl/hio_status_latch.sv
module hio_status_latch
  import hio_irq_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= sticky_next(q, set_i[i], clr_i[i]);
    end
    assign pend_o[i] = q;
  end

endmodule

// File: rtl/hio_sync_router.sv
module hio_sync_router
  import hio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_sync,
  input  logic [1:0] route,
  output logic       sync_to_irq,
  output logic       nmi_o
);

  route_e r;
  assign r = route_e'(route);
  assign sync_to_irq = frame_sync && (r == ROUTE_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) nmi_o <= 1'b0;
    else        nmi_o <= frame_sync && (r == ROUTE_NMI);
  end

endmodule

// File: rtl/hio_irq_unit.sv
module hio_irq_unit
  import hio_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              done_evt,
  input  logic              err_evt,
  input  logic              frame_sync,
  input  logic [1:0]        sync_route,
  output logic              irq_o,
  output logic              nmi_o
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic               en_wr;
  logic [NUM_SRC-1:0] en_wdata;
  logic [NUM_SRC-1:0] ack_mask;
  logic               rd_stb;
  rd_src_e            rd_src;
  logic               sync_to_irq;
  logic [NUM_SRC-1:0] event_set;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [DATA_W-1:0]  rd_mux;

  hio_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .sel(reg_sel), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata), .ack_mask(ack_mask),
    .rd_stb(rd_stb), .rd_src(rd_src)
  );

  hio_sync_router u_route (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .route(sync_route),
    .sync_to_irq(sync_to_irq), .nmi_o(nmi_o)
  );

  always_comb begin
    event_set           = '0;
    event_set[SRC_DONE] = done_evt;
    event_set[SRC_ERR]  = err_evt;
    event_set[SRC_SYNC] = sync_to_irq;
  end

  hio_status_latch #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(event_set), .clr_i(ack_mask),
    .pend_o(status_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     enable_q <= '0;
    else if (en_wr) enable_q <= en_wdata;
  end

  always_comb begin
    case (rd_src)
      RD_STATUS: rd_mux = {{PAD_W{1'b0}}, status_q};
      RD_ENABLE: rd_mux = {{PAD_W{1'b0}}, enable_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_stb ? rd_mux : '0;
  end

  assign irq_o = irq_level(status_q, enable_q);

endmodule

// File: rtl/hio_irq_chk.sv
module hio_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       reg_we,
  input logic [4:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       done_evt,
  input logic       err_evt,
  input logic       frame_sync,
  input logic [1:0] sync_route,
  input logic       irq_o,
  input logic       nmi_o,
  input logic [2:0] status,
  input logic [2:0] enable
);

  logic ack_wr;
  assign ack_wr = reg_sel && reg_we && (reg_addr == 5'h13);

  p_set_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> status[0]);

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && reg_wdata[0] && !done_evt) |=> !status[0]);

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && reg_wdata[1] && err_evt) |=> status[1]);

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status & enable) != 3'b000);

  p_route_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && sync_route != 2'b01 && !status[2]) |=> !status[2]);

  p_nmi_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && sync_route == 2'b10) |=> nmi_o);

  p_nmi_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> $past(frame_sync && sync_route == 2'b10));

  p_unused_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_we && reg_addr != 5'h11 && reg_addr != 5'h12)
      |=> reg_rdata == 8'h00);

  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && !reg_we) |=> reg_rdata == 8'h00);

endmodule

bind hio_irq_unit hio_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .done_evt(done_evt), .err_evt(err_evt), .frame_sync(frame_sync),
  .sync_route(sync_route), .irq_o(irq_o), .nmi_o(nmi_o),
  .status(status_q), .enable(enable_q)
);

// File: tb/hio_irq_unit_tb.sv
module hio_irq_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       done_evt = 1'b0;
  logic       err_evt = 1'b0;
  logic       frame_sync = 1'b0;
  logic [1:0] sync_route = 2'b00;
  logic       irq_o;
  logic       nmi_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hio_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_evt(done_evt), .err_evt(err_evt), .frame_sync(frame_sync),
    .sync_route(sync_route), .irq_o(irq_o), .nmi_o(nmi_o)
  );

  // Vector: [35:32] req, [31] sel, [30] we, [29:25] addr, [24:17] wdata,
  // [16:14] {frame_sync, err, done}, [13:12] route, [11:4] rdata, [3] irq, [2] nmi
  function automatic logic [35:0] mk(int req, bit sel, bit we, logic [4:0] a,
      logic [7:0] wd, logic [2:0] ev, logic [1:0] rt, logic [7:0] rd,
      bit irq, bit nmi);
    return {4'(req), sel, we, a, wd, ev, rt, rd, irq, nmi, 2'b00};
  endfunction

  localparam int NV = 30;
  localparam logic [35:0] VEC [NV] = '{
    mk(1,  1,0,5'h12,8'h00,3'b000,2'd0,8'h00,0,0), // R1 enable reads zero
    mk(1,  1,0,5'h11,8'h00,3'b000,2'd0,8'h00,0,0), // R1 status reads zero
    mk(2,  0,0,5'h00,8'h00,3'b001,2'd0,8'h00,0,0), // R2 done event, masked
    mk(2,  1,0,5'h11,8'h00,3'b000,2'd0,8'h01,0,0), // R2 bit0 sticky
    mk(5,  1,1,5'h12,8'hFF,3'b000,2'd0,8'h00,1,0), // R5 enable -> irq
    mk(6,  1,0,5'h12,8'h00,3'b000,2'd0,8'h07,1,0), // R6 upper bits zero
    mk(3,  1,1,5'h13,8'h02,3'b000,2'd0,8'h00,1,0), // R3 other bit untouched
    mk(3,  1,1,5'h13,8'h01,3'b000,2'd0,8'h00,0,0), // R3 clear bit0
    mk(3,  1,0,5'h11,8'h00,3'b000,2'd0,8'h00,0,0), // R3 status empty
    mk(4,  1,1,5'h13,8'h02,3'b010,2'd0,8'h00,1,0), // R4 event beats ack
    mk(4,  1,0,5'h11,8'h00,3'b000,2'd0,8'h02,1,0), // R4 bit1 kept
    mk(5,  1,1,5'h13,8'h02,3'b000,2'd0,8'h00,0,0), // R5 irq drops
    mk(7,  0,0,5'h00,8'h00,3'b100,2'd0,8'h00,0,0), // R7 route off
    mk(7,  1,0,5'h11,8'h00,3'b000,2'd0,8'h00,0,0), // R7 no status
    mk(7,  0,0,5'h00,8'h00,3'b100,2'd3,8'h00,0,0), // R7 reserved route
    mk(7,  1,0,5'h11,8'h00,3'b000,2'd3,8'h00,0,0), // R7 still no status
    mk(8,  0,0,5'h00,8'h00,3'b100,2'd1,8'h00,1,0), // R8 sync -> irq
    mk(8,  1,0,5'h11,8'h00,3'b000,2'd1,8'h04,1,0), // R8 bit2 pending
    mk(5,  1,1,5'h12,8'h03,3'b000,2'd1,8'h00,0,0), // R5 masked pending
    mk(8,  1,1,5'h13,8'h04,3'b000,2'd1,8'h00,0,0), // R8 ack bit2
    mk(9,  0,0,5'h00,8'h00,3'b100,2'd2,8'h00,0,1), // R9 nmi pulse, unmasked
    mk(9,  0,0,5'h00,8'h00,3'b000,2'd2,8'h00,0,0), // R9 one clock only
    mk(9,  1,0,5'h11,8'h00,3'b000,2'd2,8'h00,0,0), // R9 no status bit
    mk(10, 1,1,5'h05,8'hFF,3'b000,2'd0,8'h00,0,0), // R10 unused write
    mk(10, 1,0,5'h05,8'h00,3'b000,2'd0,8'h00,0,0), // R10 unused read
    mk(10, 1,1,5'h11,8'hFF,3'b000,2'd0,8'h00,0,0), // R10 status write
    mk(10, 1,0,5'h13,8'h00,3'b000,2'd0,8'h00,0,0), // R10 ack reads zero
    mk(6,  0,1,5'h12,8'h00,3'b000,2'd0,8'h00,0,0), // R6 write without sel
    mk(6,  1,0,5'h12,8'h00,3'b000,2'd0,8'h03,0,0), // R6 mask kept
    mk(11, 0,0,5'h12,8'h00,3'b000,2'd0,8'h00,0,0)  // R11 idle -> 0
  };

  task automatic chk(int req, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [35:0] v);
    @(negedge clk);
    reg_sel    = v[31];
    reg_we     = v[30];
    reg_addr   = v[29:25];
    reg_wdata  = v[24:17];
    frame_sync = v[16];
    err_evt    = v[15];
    done_evt   = v[14];
    sync_route = v[13:12];
    @(posedge clk);
    #1;
    chk(int'(v[35:32]), "rdata", reg_rdata, v[11:4]);
    chk(int'(v[35:32]), "irq", {7'b0, irq_o}, {7'b0, v[3]});
    chk(int'(v[35:32]), "nmi", {7'b0, nmi_o}, {7'b0, v[2]});
    @(negedge clk);
    reg_sel = 0; reg_we = 0; done_evt = 0; err_evt = 0; frame_sync = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(1, "reset irq", {7'b0, irq_o}, 8'h00);   // R1
    chk(1, "reset nmi", {7'b0, nmi_o}, 8'h00);   // R1
    chk(1, "reset rdata", reg_rdata, 8'h00);     // R1
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R2 error event sets bit1, then mid-run reset clears state (R1)
    apply(mk(5, 1,1,5'h12,8'h07,3'b000,2'd0,8'h00,0,0));
    apply(mk(2, 0,0,5'h00,8'h00,3'b011,2'd0,8'h00,1,0));
    apply(mk(2, 1,0,5'h11,8'h00,3'b000,2'd0,8'h03,1,0));
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    #1;
    chk(1, "irq after reset", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    rst_n = 1;
    apply(mk(1, 1,0,5'h11,8'h00,3'b000,2'd0,8'h00,0,0));
    apply(mk(1, 1,0,5'h12,8'h00,3'b000,2'd0,8'h00,0,0));

    // R9 back-to-back sync pulses each give a pulse
    apply(mk(9, 0,0,5'h00,8'h00,3'b100,2'd2,8'h00,0,1));
    apply(mk(9, 0,0,5'h00,8'h00,3'b100,2'd2,8'h00,0,1));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule